// File: doc/BRIEF.md
# Shared-Phase CORDIC Rotation Unit

This unit performs the complex rotations required by a small matrix processor that serves a multi-antenna receiver. It has two operating paths. In the first, one vectoring engine takes a single complex sample and reduces it to its magnitude and angle. In the second, a bank of NRX rotation lanes turns NRX complex samples through one common angle. The rotation lanes do not decide their own micro-rotation directions. A single shared steering stage converts the requested angle into a quadrant pre-turn and a vector of per-iteration direction bits, and every lane follows that vector in lockstep.

A 16-entry angle store records each angle measured in vector mode, at an address taken from the instruction. A later instruction can replay a stored angle into the rotation lanes by naming its read address, which avoids recomputing the angle. The unit works iteratively with one micro-rotation per clock. It captures its operands when it accepts a start and gives a one-cycle done pulse when the result is ready. Each result is multiplied by a constant that cancels the CORDIC gain, rounded to nearest, and saturated to the output width.

Top module: `shared_phase_rotator`

## Requirements
- R1: After reset, busy and done are low and mag_out, phase_out, rot_re_out and rot_im_out are all zero.
- R2: In vector mode (mode 0), mag_out is sqrt(vec_re^2 + vec_im^2) within 16 LSB, on the same Q2.14 scale as the inputs.
- R3: In vector mode, phase_out is atan2(vec_im, vec_re) within 16 units, expressed as a binary angle in which 32768 units equal pi (signed, wrapping). This holds in all four quadrants, including a negative real part.
- R4: A vector-mode operation writes its angle into the store at wr_addr. Mode 2 and mode 3 rotate every lane by the angle held at rd_addr, and distinct addresses keep distinct angles.
- R5: In mode 1 (fresh angle), each lane's output equals its input rotated by phase_in, within 16 LSB: re' = re*cos - im*sin and im' = re*sin + im*cos.
- R6: All NRX lanes apply the same rotation at once, each to its own input. Lane l occupies bits [16l+15:16l] of the packed lane ports.
- R7: done rises in the cycle after the 15th rising edge that follows the edge accepting start (ITER+1 edges). It stays high for exactly one cycle. busy is high from acceptance until done and is low while done is high.
- R8: A start that arrives while busy is ignored. The running operation finishes at its original time with its original operands and mode, and no further done follows.
- R9: Outputs change only with done. A vector operation leaves the rotation outputs unchanged, and a rotation leaves mag_out and phase_out unchanged.
- R10: Results outside the 16-bit signed range saturate to 32767 or -32768.
- R11: A rotation angle of -32768 (pi) negates every lane input, within 16 LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; honoured only when idle |
| mode | input | 2 | 0 vector, 1 rotate by phase_in, 2 or 3 rotate by stored angle |
| wr_addr | input | 4 | Store address written by a vector operation |
| rd_addr | input | 4 | Store address read by a stored-angle rotation |
| phase_in | input | 16 | Fresh rotation angle, binary angle (32768 = pi) |
| vec_re | input | 16 | Vector-mode real part, Q2.14 signed |
| vec_im | input | 16 | Vector-mode imaginary part, Q2.14 signed |
| rot_re_in | input | NRX*16 | Packed lane real parts |
| rot_im_in | input | NRX*16 | Packed lane imaginary parts |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-ready pulse |
| mag_out | output | 16 | Gain-corrected magnitude |
| phase_out | output | 16 | Measured angle, binary angle |
| rot_re_out | output | NRX*16 | Packed rotated real parts |
| rot_im_out | output | NRX*16 | Packed rotated imaginary parts |

## Verification
The rotation path is swept through 64 evenly spaced angles around the full circle. The four lanes carry inputs in different quadrants, so any lane that mixes up cosine and sine signs or steers on its own stands out from the others. The vector path is swept through 64 angles at two magnitudes, which separates quadrant pre-turn faults from faults in magnitude scaling. Further checks cover stored-angle replay from two separate addresses, the exact angle pi, inputs that drive the results into saturation, and a start issued in the middle of a run. These targeted cases each exercise a single corner, so an error there cannot be hidden by a correct result elsewhere.

// File: rtl/cordic_rot_pkg.sv
package cordic_rot_pkg;
  localparam int PHASE_W   = 16;
  localparam int GAIN_FRAC = 15;

  typedef enum logic [1:0] {
    OP_VECTOR     = 2'd0,
    OP_ROT_FRESH  = 2'd1,
    OP_ROT_STORED = 2'd2,
    OP_ROT_ALT    = 2'd3
  } op_mode_e;

  typedef enum logic [1:0] {
    PRE_NONE    = 2'd0,
    PRE_PLUS90  = 2'd1,
    PRE_MINUS90 = 2'd2
  } prerot_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } run_state_e;

  localparam logic signed [PHASE_W-1:0] QUARTER_TURN = 16'sd16384;

  // arctan(2^-i) as a binary angle, 32768 units per half turn
  function automatic logic signed [PHASE_W-1:0] atan_step(input int i);
    case (i)
      0:  return 16'sd8192;
      1:  return 16'sd4836;
      2:  return 16'sd2555;
      3:  return 16'sd1297;
      4:  return 16'sd651;
      5:  return 16'sd326;
      6:  return 16'sd163;
      7:  return 16'sd81;
      8:  return 16'sd41;
      9:  return 16'sd20;
      10: return 16'sd10;
      11: return 16'sd5;
      12: return 16'sd3;
      13: return 16'sd1;
      14: return 16'sd1;
      default: return 16'sd0;
    endcase
  endfunction

  // multiply by the inverse CORDIC gain (19898/32768 ~ 0.60725) and round to nearest
  function automatic logic signed [47:0] gain_scale(input logic signed [31:0] v,
                                                    input int unsigned drop);
    logic signed [47:0] prod;
    logic signed [47:0] half;
    prod = 48'(v) * 48'sd19898;
    half = 48'sd1 <<< (drop - 1);
    return (prod + half) >>> drop;
  endfunction

  // clamp to a w-bit signed range
  function automatic logic signed [47:0] clamp_signed(input logic signed [47:0] v,
                                                      input int unsigned w);
    logic signed [47:0] hi;
    logic signed [47:0] lo;
    hi = (48'sd1 <<< (w - 1)) - 48'sd1;
    lo = -(48'sd1 <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction
endpackage

// File: rtl/phase_director.sv
module phase_director
  import cordic_rot_pkg::*;
#(
  parameter int ITER = 14
) (
  input  logic signed [PHASE_W-1:0] phase,
  output prerot_e                   pre,
  output logic [ITER-1:0]           dirs
);
  logic signed [PHASE_W:0] resid;

  always_comb begin
    if (phase > QUARTER_TURN) begin
      pre   = PRE_PLUS90;
      resid = 17'(phase) - 17'(QUARTER_TURN);
    end else if (phase < -QUARTER_TURN) begin
      pre   = PRE_MINUS90;
      resid = 17'(phase) + 17'(QUARTER_TURN);
    end else begin
      pre   = PRE_NONE;
      resid = 17'(phase);
    end
    for (int i = 0; i < ITER; i++) begin
      dirs[i] = ~resid[PHASE_W];
      if (dirs[i]) resid = resid - 17'(atan_step(i));
      else         resid = resid + 17'(atan_step(i));
    end
  end
endmodule

// File: rtl/cordic_lane.sv
module cordic_lane
  import cordic_rot_pkg::*;
#(
  parameter int IW     = 21,
  parameter int ITER_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 step,
  input  logic                 dir,
  input  logic [ITER_W-1:0]    shamt,
  input  prerot_e              pre,
  input  logic signed [IW-1:0] x_in,
  input  logic signed [IW-1:0] y_in,
  output logic signed [IW-1:0] x_q,
  output logic signed [IW-1:0] y_q
);
  logic signed [IW-1:0] x_sh;
  logic signed [IW-1:0] y_sh;
  assign x_sh = x_q >>> shamt;
  assign y_sh = y_q >>> shamt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (load) begin
      case (pre)
        PRE_PLUS90:  begin x_q <= -y_in; y_q <= x_in;  end
        PRE_MINUS90: begin x_q <= y_in;  y_q <= -x_in; end
        default:     begin x_q <= x_in;  y_q <= y_in;  end
      endcase
    end else if (step) begin
      if (dir) begin
        x_q <= x_q - y_sh;
        y_q <= y_q + x_sh;
      end else begin
        x_q <= x_q + y_sh;
        y_q <= y_q - x_sh;
      end
    end
  end
endmodule

// File: rtl/cordic_vectoring.sv
module cordic_vectoring
  import cordic_rot_pkg::*;
#(
  parameter int IW     = 21,
  parameter int ITER_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic                      step,
  input  logic [ITER_W-1:0]         shamt,
  input  logic signed [IW-1:0]      x_in,
  input  logic signed [IW-1:0]      y_in,
  output logic signed [IW-1:0]      x_q,
  output logic signed [PHASE_W-1:0] z_q
);
  logic signed [IW-1:0] y_q;
  logic signed [IW-1:0] x_sh;
  logic signed [IW-1:0] y_sh;
  logic                 y_neg;
  assign x_sh  = x_q >>> shamt;
  assign y_sh  = y_q >>> shamt;
  assign y_neg = y_q[IW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
      z_q <= '0;
    end else if (load) begin
      if (x_in[IW-1]) begin
        if (!y_in[IW-1]) begin
          x_q <= y_in;  y_q <= -x_in; z_q <= QUARTER_TURN;
        end else begin
          x_q <= -y_in; y_q <= x_in;  z_q <= -QUARTER_TURN;
        end
      end else begin
        x_q <= x_in; y_q <= y_in; z_q <= '0;
      end
    end else if (step) begin
      if (!y_neg) begin
        x_q <= x_q + y_sh;
        y_q <= y_q - x_sh;
        z_q <= z_q + atan_step(int'(shamt));
      end else begin
        x_q <= x_q - y_sh;
        y_q <= y_q + x_sh;
        z_q <= z_q - atan_step(int'(shamt));
      end
    end
  end

  AST_VEC_X_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !x_q[IW-1]); // R3
endmodule

// File: rtl/phase_store.sv
module phase_store
  import cordic_rot_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [PHASE_W-1:0] wdata,
  input  logic [AW-1:0]      raddr,
  output logic [PHASE_W-1:0] rdata
);
  logic [PHASE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/shared_phase_rotator.sv
module shared_phase_rotator
  import cordic_rot_pkg::*;
#(
  parameter int NRX   = 4,
  parameter int W     = 16,
  parameter int ITER  = 14,
  parameter int DEPTH = 16,
  parameter int GUARD = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           mode,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  input  logic [PHASE_W-1:0]   phase_in,
  input  logic [W-1:0]         vec_re,
  input  logic [W-1:0]         vec_im,
  input  logic [NRX*W-1:0]     rot_re_in,
  input  logic [NRX*W-1:0]     rot_im_in,
  output logic                 busy,
  output logic                 done,
  output logic [W-1:0]         mag_out,
  output logic [PHASE_W-1:0]   phase_out,
  output logic [NRX*W-1:0]     rot_re_out,
  output logic [NRX*W-1:0]     rot_im_out
);
  localparam int AW     = $clog2(DEPTH);
  localparam int IW     = W + 2 + GUARD;
  localparam int ITER_W = $clog2(ITER);
  localparam int DROP   = GAIN_FRAC + GUARD;

  function automatic logic signed [IW-1:0] widen(input logic [W-1:0] v);
    logic signed [IW-1:0] t;
    t = IW'($signed(v));
    return t <<< GUARD;
  endfunction

  function automatic logic [W-1:0] finish_value(input logic signed [IW-1:0] v);
    logic signed [47:0] s;
    s = clamp_signed(gain_scale(32'(v), DROP), W);
    return s[W-1:0];
  endfunction

  // control state
  run_state_e          state;
  logic [ITER_W-1:0]   iter_q;
  logic                op_vec_q;
  logic [AW-1:0]       wr_addr_q;
  logic [ITER-1:0]     dir_q;

  // named internal events
  logic                accept_start;
  logic                step_now;
  logic                last_iter;
  logic                finish;
  logic                mode_is_vec;

  op_mode_e            mode_e;
  assign mode_e       = op_mode_e'(mode);
  assign mode_is_vec  = (mode_e == OP_VECTOR);
  assign accept_start = start && (state == ST_IDLE);
  assign step_now     = (state == ST_RUN);
  assign last_iter    = step_now && (iter_q == ITER_W'(ITER - 1));
  assign finish       = (state == ST_FIN);
  assign busy         = (state != ST_IDLE);

  // shared angle selection and steering
  logic [PHASE_W-1:0]  store_rdata;
  logic signed [PHASE_W-1:0] sel_phase;
  prerot_e             dir_pre;
  logic [ITER-1:0]     dir_vec;
  logic                lane_dir;

  assign sel_phase = mode[1] ? $signed(store_rdata) : $signed(phase_in);
  assign lane_dir  = dir_q[iter_q];

  phase_director #(.ITER(ITER)) u_director (
    .phase (sel_phase),
    .pre   (dir_pre),
    .dirs  (dir_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      iter_q    <= '0;
      op_vec_q  <= 1'b0;
      wr_addr_q <= '0;
      dir_q     <= '0;
      done      <= 1'b0;
    end else begin
      done <= finish;
      case (state)
        ST_IDLE: if (accept_start) begin
          state     <= ST_RUN;
          iter_q    <= '0;
          op_vec_q  <= mode_is_vec;
          wr_addr_q <= wr_addr;
          dir_q     <= dir_vec;
        end
        ST_RUN: begin
          iter_q <= iter_q + 1'b1;
          if (last_iter) state <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // vectoring engine
  logic signed [IW-1:0]      vx_q;
  logic signed [PHASE_W-1:0] vz_q;

  cordic_vectoring #(.IW(IW), .ITER_W(ITER_W)) u_vector (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept_start && mode_is_vec),
    .step  (step_now && op_vec_q),
    .shamt (iter_q),
    .x_in  (widen(vec_re)),
    .y_in  (widen(vec_im)),
    .x_q   (vx_q),
    .z_q   (vz_q)
  );

  phase_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (finish && op_vec_q),
    .waddr (wr_addr_q),
    .wdata (vz_q),
    .raddr (rd_addr),
    .rdata (store_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag_out   <= '0;
      phase_out <= '0;
    end else if (finish && op_vec_q) begin
      mag_out   <= finish_value(vx_q);
      phase_out <= vz_q;
    end
  end

  // rotation lanes, all steered by the same direction bits
  for (genvar l = 0; l < NRX; l++) begin : g_lane
    logic signed [IW-1:0] lx_q;
    logic signed [IW-1:0] ly_q;
    logic [W-1:0]         re_q;
    logic [W-1:0]         im_q;

    cordic_lane #(.IW(IW), .ITER_W(ITER_W)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept_start && !mode_is_vec),
      .step  (step_now && !op_vec_q),
      .dir   (lane_dir),
      .shamt (iter_q),
      .pre   (dir_pre),
      .x_in  (widen(rot_re_in[l*W +: W])),
      .y_in  (widen(rot_im_in[l*W +: W])),
      .x_q   (lx_q),
      .y_q   (ly_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        re_q <= '0;
        im_q <= '0;
      end else if (finish && !op_vec_q) begin
        re_q <= finish_value(lx_q);
        im_q <= finish_value(ly_q);
      end
    end

    assign rot_re_out[l*W +: W] = re_q;
    assign rot_im_out[l*W +: W] = im_q;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7
  AST_ITER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    step_now |-> (iter_q < ITER_W'(ITER))); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (step_now && start) |=> ($stable(op_vec_q) && $stable(dir_q) && busy)); // R8
  AST_MAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mag_out) |-> (done && op_vec_q)); // R9
  AST_ROT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rot_re_out) |-> (done && !op_vec_q)); // R9
endmodule

// File: tb/test_shared_phase_rotator.sv
module test_shared_phase_rotator;
  localparam int CLK_PERIOD = 10;
  localparam int NRX = 4;
  localparam int W   = 16;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [3:0] wr_addr = 4'd0;
  logic [3:0] rd_addr = 4'd0;
  logic [15:0] phase_in = 16'd0;
  logic [15:0] vec_re = 16'd0;
  logic [15:0] vec_im = 16'd0;
  logic [NRX*W-1:0] rot_re_in = '0;
  logic [NRX*W-1:0] rot_im_in = '0;
  logic busy, done;
  logic [15:0] mag_out, phase_out;
  logic [NRX*W-1:0] rot_re_out, rot_im_out;

  int checks = 0;
  int errors = 0;
  int lane_re[NRX];
  int lane_im[NRX];
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shared_phase_rotator i_shared_phase_rotator (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .wr_addr(wr_addr), .rd_addr(rd_addr), .phase_in(phase_in),
    .vec_re(vec_re), .vec_im(vec_im),
    .rot_re_in(rot_re_in), .rot_im_in(rot_im_in),
    .busy(busy), .done(done), .mag_out(mag_out), .phase_out(phase_out),
    .rot_re_out(rot_re_out), .rot_im_out(rot_im_out)
  );

  function automatic int clamp16(input real v);
    int r;
    if (v > 32767.0) return 32767;
    if (v < -32768.0) return -32768;
    r = int'(v);
    return r;
  endfunction

  function automatic int wrap_diff(input int d);
    int r;
    r = d;
    while (r > 32767) r -= 65536;
    while (r < -32768) r += 65536;
    return r;
  endfunction

  task automatic check_near(input string req, input string what, input int act,
                            input int exp, input int tol);
    int d;
    d = act - exp;
    checks++;
    if (d > tol || d < -tol) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_phase(input string req, input int act, input int exp, input int tol);
    int d;
    d = wrap_diff(act - exp);
    checks++;
    if (d > tol || d < -tol) begin
      errors++;
      $display("FAIL %s phase: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pack_lanes();
    for (int l = 0; l < NRX; l++) begin
      rot_re_in[l*W +: W] = 16'(lane_re[l]);
      rot_im_in[l*W +: W] = 16'(lane_im[l]);
    end
  endtask

  function automatic int out_re(input int l);
    return int'($signed(rot_re_out[l*W +: W]));
  endfunction
  function automatic int out_im(input int l);
    return int'($signed(rot_im_out[l*W +: W]));
  endfunction

  task automatic run_op(input logic [1:0] md, input int ph, input logic [3:0] wa,
                        input logic [3:0] ra, output int lat);
    @(negedge clk);
    mode = md; phase_in = 16'(ph); wr_addr = wa; rd_addr = ra; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic check_rot(input string req, input int ph, input int tol);
    real th, xr, yr;
    th = real'(ph) * PI / 32768.0;
    for (int l = 0; l < NRX; l++) begin
      xr = real'(lane_re[l]) * $cos(th) - real'(lane_im[l]) * $sin(th);
      yr = real'(lane_re[l]) * $sin(th) + real'(lane_im[l]) * $cos(th);
      check_near(req, $sformatf("lane%0d re ph=%0d", l, ph), out_re(l), clamp16(xr), tol);
      check_near(req, $sformatf("lane%0d im ph=%0d", l, ph), out_im(l), clamp16(yr), tol);
    end
  endtask

  function automatic int exp_angle(input int re, input int im);
    return int'($atan2(real'(im), real'(re)) * 32768.0 / PI);
  endfunction

  task automatic check_vec(input string rm, input string rp, input int re, input int im);
    real m;
    m = $sqrt(real'(re) * real'(re) + real'(im) * real'(im));
    check_near(rm, "magnitude", int'($signed(mag_out)), clamp16(m), 16);
    check_phase(rp, int'($signed(phase_out)), exp_angle(re, im), 16);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int lat;
    int held_mag, held_ph;
    int held_re[NRX];
    int seen_done;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check_near("R1", "busy", int'(busy), 0, 0);
    check_near("R1", "done", int'(done), 0, 0);
    check_near("R1", "mag_out", int'(mag_out), 0, 0);
    check_near("R1", "phase_out", int'(phase_out), 0, 0);
    check_near("R1", "rot_re_out", int'(rot_re_out != '0), 0, 0);
    check_near("R1", "rot_im_out", int'(rot_im_out != '0), 0, 0);

    // R5 R6 R7: rotation sweep, lanes in distinct quadrants
    lane_re[0] = 12000; lane_im[0] = 0;
    lane_re[1] = 0;     lane_im[1] = -9000;
    lane_re[2] = -7000; lane_im[2] = 5000;
    lane_re[3] = 3000;  lane_im[3] = 11000;
    pack_lanes();
    for (int k = 0; k < 64; k++) begin
      run_op(2'd1, k * 1024, 4'd0, 4'd0, lat);
      check_near("R7", "latency", lat, 16, 0);
      check_rot("R5_R6", $signed(16'(k * 1024)), 16);
      @(negedge clk);
      check_near("R7", "done width", int'(done), 0, 0);
    end

    // R11: rotation by pi
    lane_re[0] = 15000; lane_im[0] = -4000;
    lane_re[1] = -20000; lane_im[1] = 8000;
    lane_re[2] = 1; lane_im[2] = 25000;
    lane_re[3] = -3000; lane_im[3] = -3000;
    pack_lanes();
    run_op(2'd1, -32768, 4'd0, 4'd0, lat);
    for (int l = 0; l < NRX; l++) begin
      check_near("R11", "neg re", out_re(l), -lane_re[l], 16);
      check_near("R11", "neg im", out_im(l), -lane_im[l], 16);
    end
    for (int l = 0; l < NRX; l++) held_re[l] = out_re(l);

    // R2 R3: vector sweep over angles and two magnitudes
    for (int s = 0; s < 2; s++) begin
      for (int k = 0; k < 64; k++) begin
        real a, m;
        int re, im;
        m = (s == 0) ? 10000.0 : 24000.0;
        a = 2.0 * PI * real'(k) / 64.0;
        re = int'(m * $cos(a));
        im = int'(m * $sin(a));
        vec_re = 16'(re); vec_im = 16'(im);
        run_op(2'd0, 0, 4'(k), 4'd0, lat);
        check_near("R7", "vector latency", lat, 16, 0);
        check_vec("R2", "R3", re, im);
      end
    end

    // R9: vector runs left rotation outputs alone
    for (int l = 0; l < NRX; l++)
      check_near("R9", "rot held after vector", out_re(l), held_re[l], 0);

    // R4: store two angles and replay them
    vec_re = 16'(-9000); vec_im = 16'(4000);
    run_op(2'd0, 0, 4'd3, 4'd0, lat);
    vec_re = 16'(5000); vec_im = 16'(-12000);
    run_op(2'd0, 0, 4'd12, 4'd0, lat);
    held_mag = int'($signed(mag_out));
    held_ph  = int'($signed(phase_out));
    lane_re[0] = 12000; lane_im[0] = 0;
    lane_re[1] = 0;     lane_im[1] = 12000;
    lane_re[2] = -8000; lane_im[2] = -8000;
    lane_re[3] = 6000;  lane_im[3] = -2000;
    pack_lanes();
    run_op(2'd2, 0, 4'd0, 4'd3, lat);
    check_rot("R4", exp_angle(-9000, 4000), 24);
    run_op(2'd3, 0, 4'd0, 4'd12, lat);
    check_rot("R4", exp_angle(5000, -12000), 24);
    // R9: rotations left vector outputs alone
    check_near("R9", "mag held", int'($signed(mag_out)), held_mag, 0);
    check_near("R9", "phase held", int'($signed(phase_out)), held_ph, 0);

    // R8: start during a run is ignored
    pack_lanes();
    @(negedge clk);
    mode = 2'd1; phase_in = 16'd4096; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    check_near("R8", "busy mid-run", int'(busy), 1, 0);
    mode = 2'd0; phase_in = 16'd0; vec_re = 16'd100; vec_im = 16'd100;
    rot_re_in = '0; rot_im_in = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 6;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    check_near("R8", "original latency", lat, 16, 0);
    check_rot("R8", 4096, 16);
    check_near("R8", "mag untouched", int'($signed(mag_out)), held_mag, 0);
    seen_done = 0;
    repeat (20) begin
      @(negedge clk);
      if (done) seen_done++;
    end
    check_near("R8", "no extra done", seen_done, 0, 0);

    // R10: saturation in both paths
    vec_re = 16'h8000; vec_im = 16'h8000;
    run_op(2'd0, 0, 4'd1, 4'd0, lat);
    check_near("R10", "mag saturates", int'($signed(mag_out)), 32767, 0);
    check_phase("R3", int'($signed(phase_out)), -24576, 16);
    lane_re[0] = 32767;  lane_im[0] = 32767;
    lane_re[1] = -32768; lane_im[1] = -32768;
    lane_re[2] = 20000;  lane_im[2] = 0;
    lane_re[3] = 0;      lane_im[3] = -20000;
    pack_lanes();
    run_op(2'd1, 8192, 4'd0, 4'd0, lat);
    check_near("R10", "lane0 im high", out_im(0), 32767, 0);
    check_near("R10", "lane1 im low", out_im(1), -32768, 0);
    check_rot("R10", 8192, 16);

    finish_run();
  end
endmodule